// File: doc/BRIEF.md
# Dual-Accumulator Fixed-Point MAC Engine

This block is the arithmetic heart of a signal-processing datapath. It holds two 40-bit accumulators and updates one of them per clock. The update can be a plain product, a negated product, a running sum or difference of products, the square of an operand difference, a clear, or an exchange between the two accumulators. A 17x17-bit signed multiplier handles both signed and unsigned 16-bit operands. A 42-bit adder computes the exact result, so overflow past the 32-bit and 40-bit boundaries is always seen before any clamp is applied.

The controls are sampled on every cycle. They choose integer or fractional products, signed or unsigned operands, and whether each accumulator saturates. When saturation is on, it clamps either at the 1.31 boundary or at the full 9.31 boundary. Sticky overflow flags record both boundaries for each accumulator. A separate combinational store port returns the upper word of either accumulator as a 16-bit value. That word is rounded either half-up or half-to-even, and it can optionally be clamped when the guard bits show it does not fit.

Top module: `dual_acc_mac`

## Requirements
- R1: After reset both accumulators, all four overflow flags and the store word are zero.
- R2: Opcodes (4-bit `op`): 0 leaves both accumulators unchanged; 1 clears the target; 2 loads x*y; 3 loads -(x*y). Any code above 10 also leaves both accumulators unchanged.
- R3: With `unsigned_mode`=1 the operands are zero-extended to 17 bits before multiplying. Otherwise they are sign-extended.
- R4: With `frac_mode`=1 the product is doubled. A signed fractional 0x8000*0x8000 gives 0x00_7FFF_FFFF. The unsigned fractional product of the same operands is not clamped.
- R5: Opcode 4 adds x*y to the target and opcode 5 subtracts it.
- R6: Opcode 6 loads (x-y)^2 and opcode 7 adds (x-y)^2 to the target. The difference is formed at 17 bits under the same signedness rule as R3.
- R7: Opcode 8 sets target = target + other accumulator, opcode 9 sets target = target - other, and opcode 10 sets target = -target. x and y have no effect on these opcodes.
- R8: `acc_sel` (0 = A, 1 = B) picks the target. The other accumulator keeps its value.
- R9: When the target's enable (`sat_en_a` or `sat_en_b`) is set and `super_sat`=0, an exact result outside the signed 32-bit range is clamped to 0x00_7FFF_FFFF or 0xFF_8000_0000. The other accumulator's enable has no effect on the write.
- R10: When the target's enable is set and `super_sat`=1, a result outside the 40-bit range is clamped to 0x7F_FFFF_FFFF or 0x80_0000_0000. With the enable clear, the result wraps modulo 2^40.
- R11: `ovf` bit 0 / bit 1 record A leaving the 32-bit / 40-bit signed range, and bits 2 / 3 do the same for B. Each flag is judged on the exact result before saturation. A flag stays set until `ovf_clr`, which clears all four on the next edge.
- R12: With `convergent`=0 the store word is bits 31:16 of the accumulator, plus one when bit 15 is set.
- R13: With `convergent`=1 an exact tie (low 16 bits = 0x8000) rounds up only when bit 16 is 1. Other cases round to the nearest value.
- R14: With `store_sat`=1, if bits 39:31 of the rounded value are not all equal, the store word is 0x7FFF for a positive value and 0x8000 for a negative one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Operation code |
| acc_sel | input | 1 | Target accumulator, 0 = A, 1 = B |
| x | input | 16 | First operand |
| y | input | 16 | Second operand |
| frac_mode | input | 1 | Fractional product (doubled) |
| unsigned_mode | input | 1 | Treat operands as unsigned |
| convergent | input | 1 | Round half to even on the store path |
| sat_en_a | input | 1 | Saturation enable for A |
| sat_en_b | input | 1 | Saturation enable for B |
| super_sat | input | 1 | Clamp at 40 bits instead of 32 |
| store_sat | input | 1 | Clamp the store word |
| store_sel | input | 1 | Accumulator read by the store port |
| ovf_clr | input | 1 | Clear all overflow flags |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf | output | 4 | Sticky overflow flags |
| store_word | output | 16 | Rounded, optionally clamped upper word |

## Verification
A chained vector table runs every opcode against both accumulators. Each step depends on the previous one, so a wrong sign, a swapped accumulator or a leaking operand on an accumulator-to-accumulator opcode shows up in later values. The same operand pair 0xFFFF*0xFFFF and 0x8000*0x8000 is applied under signed, unsigned, integer and fractional modes, which separates the extension rule from the doubling and the clamp. Long runs of accumulation drive the results past both boundaries, with saturation on and off and with the enable given to the wrong accumulator. Store values with low halves just below 0x8000, at 0x8000 with even and odd bit 16, and just above 0x8000 separate the two rounding rules.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [3:0] {
        OP_HOLD = 4'd0,
        OP_CLR  = 4'd1,
        OP_MPY  = 4'd2,
        OP_MPYN = 4'd3,
        OP_MAC  = 4'd4,
        OP_MSC  = 4'd5,
        OP_SQ   = 4'd6,
        OP_SQAC = 4'd7,
        OP_ADD  = 4'd8,
        OP_SUB  = 4'd9,
        OP_NEG  = 4'd10
    } mac_op_e;
endpackage

// File: rtl/mac_product.sv
module mac_product #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic [OP_W-1:0]  x,
    input  logic [OP_W-1:0]  y,
    input  logic             frac_mode,
    input  logic             unsigned_mode,
    input  logic             square,
    output logic [ACC_W-1:0] prod
);
    localparam int MW = OP_W + 1;
    localparam int PW = 2 * MW;
    localparam int FB = 2 * OP_W - 1;

    logic signed [MW-1:0] xe, ye, diff, ma, mb;
    logic signed [PW-1:0] full;
    logic [ACC_W-1:0]     ext;
    logic                 corner;

    always_comb begin
        xe   = unsigned_mode ? {1'b0, x} : {x[OP_W-1], x};
        ye   = unsigned_mode ? {1'b0, y} : {y[OP_W-1], y};
        diff = xe - ye;
        ma   = square ? diff : xe;
        mb   = square ? diff : ye;
        full = ma * mb;
        ext  = {{(ACC_W-PW){full[PW-1]}}, full};
        corner = frac_mode && !unsigned_mode && !square &&
                 (x == {1'b1, {(OP_W-1){1'b0}}}) &&
                 (y == {1'b1, {(OP_W-1){1'b0}}});
        if (corner)
            prod = {{(ACC_W-FB){1'b0}}, {FB{1'b1}}};
        else if (frac_mode)
            prod = {ext[ACC_W-2:0], 1'b0};
        else
            prod = ext;
    end
endmodule

// File: rtl/mac_addsat.sv
module mac_addsat #(
    parameter int ACC_W  = 40,
    parameter int SAT_LO = 31
) (
    input  logic [ACC_W-1:0] base,
    input  logic [ACC_W-1:0] addend,
    input  logic             negate,
    input  logic             sat_en,
    input  logic             super_sat,
    output logic [ACC_W-1:0] result,
    output logic             ov_lo,
    output logic             ov_hi
);
    localparam int SW = ACC_W + 2;

    logic signed [SW-1:0] b_w, a_w, sum;
    logic [SW-1:ACC_W-1]  top_hi;
    logic [SW-1:SAT_LO]   top_lo;
    logic                 neg;

    always_comb begin
        b_w    = {{2{base[ACC_W-1]}}, base};
        a_w    = {{2{addend[ACC_W-1]}}, addend};
        sum    = negate ? (b_w - a_w) : (b_w + a_w);
        top_hi = sum[SW-1:ACC_W-1];
        top_lo = sum[SW-1:SAT_LO];
        ov_hi  = !((&top_hi) || !(|top_hi));
        ov_lo  = !((&top_lo) || !(|top_lo));
        neg    = sum[SW-1];
        if (sat_en && super_sat && ov_hi)
            result = neg ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
        else if (sat_en && !super_sat && ov_lo)
            result = neg ? {{(ACC_W-SAT_LO){1'b1}}, {SAT_LO{1'b0}}}
                         : {{(ACC_W-SAT_LO){1'b0}}, {SAT_LO{1'b1}}};
        else
            result = sum[ACC_W-1:0];
    end
endmodule

// File: rtl/mac_store.sv
module mac_store #(
    parameter int ACC_W  = 40,
    parameter int OP_W   = 16,
    parameter int SAT_LO = 31
) (
    input  logic [ACC_W-1:0] acc,
    input  logic             convergent,
    input  logic             store_sat,
    output logic [OP_W-1:0]  word
);
    localparam int RP = OP_W;
    localparam int HW = ACC_W - RP + 1;
    localparam int GL = SAT_LO - RP;

    logic          half, rest_nz, inc;
    logic [HW-1:0] r_hi;
    logic [HW-1:GL] guard;
    logic          oflow;

    always_comb begin
        half    = acc[RP-1];
        rest_nz = |acc[RP-2:0];
        inc     = convergent ? (half && (rest_nz || acc[RP])) : half;
        r_hi    = {acc[ACC_W-1], acc[ACC_W-1:RP]} + {{(HW-1){1'b0}}, inc};
        guard   = r_hi[HW-1:GL];
        oflow   = !((&guard) || !(|guard));
        if (store_sat && oflow)
            word = r_hi[HW-1] ? {1'b1, {(OP_W-1){1'b0}}} : {1'b0, {(OP_W-1){1'b1}}};
        else
            word = r_hi[OP_W-1:0];
    end
endmodule

// File: rtl/dual_acc_mac.sv
module dual_acc_mac #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op,
    input  logic             acc_sel,
    input  logic [OP_W-1:0]  x,
    input  logic [OP_W-1:0]  y,
    input  logic             frac_mode,
    input  logic             unsigned_mode,
    input  logic             convergent,
    input  logic             sat_en_a,
    input  logic             sat_en_b,
    input  logic             super_sat,
    input  logic             store_sat,
    input  logic             store_sel,
    input  logic             ovf_clr,
    output logic [ACC_W-1:0] acc_a,
    output logic [ACC_W-1:0] acc_b,
    output logic [3:0]       ovf,
    output logic [OP_W-1:0]  store_word
);
    import mac_pkg::*;

    localparam int N_ACC  = 2;
    localparam int SAT_LO = 2 * OP_W - 1;

    typedef struct packed {
        logic [N_ACC-1:0][ACC_W-1:0] acc;
        logic [2*N_ACC-1:0]          ovf;
    } st_t;

    st_t st_d, st_q;

    mac_op_e          op_e;
    logic             square, write, negate, use_own, use_prod, use_other;
    logic [ACC_W-1:0] prod;
    logic [N_ACC-1:0] sat_vec;
    logic [N_ACC-1:0][ACC_W-1:0] base_w, add_w, res_w;
    logic [N_ACC-1:0] lo_w, hi_w;

    always_comb begin
        op_e      = mac_op_e'(op);
        square    = (op_e == OP_SQ) || (op_e == OP_SQAC);
        write     = 1'b1;
        negate    = 1'b0;
        use_own   = 1'b0;
        use_prod  = 1'b0;
        use_other = 1'b0;
        unique case (op_e)
            OP_CLR:         ;
            OP_MPY, OP_SQ:  use_prod = 1'b1;
            OP_MPYN:        begin use_prod = 1'b1; negate = 1'b1; end
            OP_MAC, OP_SQAC: begin use_own = 1'b1; use_prod = 1'b1; end
            OP_MSC:         begin use_own = 1'b1; use_prod = 1'b1; negate = 1'b1; end
            OP_ADD:         begin use_own = 1'b1; use_other = 1'b1; end
            OP_SUB:         begin use_own = 1'b1; use_other = 1'b1; negate = 1'b1; end
            OP_NEG:         negate = 1'b1;
            default:        write = 1'b0;
        endcase
        sat_vec = {sat_en_b, sat_en_a};
    end

    mac_product #(.OP_W(OP_W), .ACC_W(ACC_W)) u_prod (
        .x(x), .y(y), .frac_mode(frac_mode), .unsigned_mode(unsigned_mode),
        .square(square), .prod(prod)
    );

    for (genvar i = 0; i < N_ACC; i++) begin : g_acc
        localparam int J = N_ACC - 1 - i;
        always_comb begin
            base_w[i] = use_own ? st_q.acc[i] : '0;
            if (use_prod)
                add_w[i] = prod;
            else if (use_other)
                add_w[i] = st_q.acc[J];
            else if (op_e == OP_NEG)
                add_w[i] = st_q.acc[i];
            else
                add_w[i] = '0;
        end
        mac_addsat #(.ACC_W(ACC_W), .SAT_LO(SAT_LO)) u_add (
            .base(base_w[i]), .addend(add_w[i]), .negate(negate),
            .sat_en(sat_vec[i]), .super_sat(super_sat),
            .result(res_w[i]), .ov_lo(lo_w[i]), .ov_hi(hi_w[i])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.ovf = ovf_clr ? '0 : st_q.ovf;
        for (int i = 0; i < N_ACC; i++) begin
            if (write && (acc_sel == 1'(i))) begin
                st_d.acc[i]       = res_w[i];
                st_d.ovf[2*i]     = st_d.ovf[2*i] | lo_w[i];
                st_d.ovf[2*i + 1] = st_d.ovf[2*i + 1] | hi_w[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mac_store #(.ACC_W(ACC_W), .OP_W(OP_W), .SAT_LO(SAT_LO)) u_store (
        .acc(store_sel ? st_q.acc[1] : st_q.acc[0]),
        .convergent(convergent), .store_sat(store_sat), .word(store_word)
    );

    assign acc_a = st_q.acc[0];
    assign acc_b = st_q.acc[1];
    assign ovf   = st_q.ovf;
endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op,
    input logic             acc_sel,
    input logic             sat_en_a,
    input logic             super_sat,
    input logic             store_sat,
    input logic             store_sel,
    input logic             ovf_clr,
    input logic [ACC_W-1:0] acc_a,
    input logic [ACC_W-1:0] acc_b,
    input logic [3:0]       ovf,
    input logic [OP_W-1:0]  store_word
);
    localparam int SAT_LO = 2 * OP_W - 1;

    logic [ACC_W-1:0] sel_acc;
    assign sel_acc = store_sel ? acc_b : acc_a;

    a_r8_b_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel == 1'b0) |=> $stable(acc_b));

    a_r8_a_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_sel == 1'b1) |=> $stable(acc_a));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd0 || op > 4'd10) |=> ($stable(acc_a) && $stable(acc_b)));

    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_clr |=> ((ovf & $past(ovf)) == $past(ovf)));

    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && op == 4'd0) |=> (ovf == 4'd0));

    a_r9_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en_a && !super_sat && acc_sel == 1'b0 && op >= 4'd1 && op <= 4'd10)
        |=> ((&acc_a[ACC_W-1:SAT_LO]) || !(|acc_a[ACC_W-1:SAT_LO])));

    a_r14_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        (store_sat && !((&sel_acc[ACC_W-1:SAT_LO]) || !(|sel_acc[ACC_W-1:SAT_LO])))
        |-> (store_word == {1'b0, {(OP_W-1){1'b1}}} ||
             store_word == {1'b1, {(OP_W-1){1'b0}}}));
endmodule

bind dual_acc_mac mac_checker #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op(op), .acc_sel(acc_sel),
    .sat_en_a(sat_en_a), .super_sat(super_sat), .store_sat(store_sat),
    .store_sel(store_sel), .ovf_clr(ovf_clr), .acc_a(acc_a), .acc_b(acc_b),
    .ovf(ovf), .store_word(store_word)
);

// File: tb/sim_dual_acc_mac.sv
module sim_dual_acc_mac;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = '0;
    logic        acc_sel = 1'b0;
    logic [15:0] x = '0, y = '0;
    logic        frac_mode = 1'b0, unsigned_mode = 1'b0, convergent = 1'b0;
    logic        sat_en_a = 1'b0, sat_en_b = 1'b0, super_sat = 1'b0;
    logic        store_sat = 1'b0, store_sel = 1'b0, ovf_clr = 1'b0;
    logic [39:0] acc_a, acc_b;
    logic [3:0]  ovf;
    logic [15:0] store_word;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    dual_acc_mac u0 (
        .clk(clk), .rst_n(rst_n), .op(op), .acc_sel(acc_sel), .x(x), .y(y),
        .frac_mode(frac_mode), .unsigned_mode(unsigned_mode), .convergent(convergent),
        .sat_en_a(sat_en_a), .sat_en_b(sat_en_b), .super_sat(super_sat),
        .store_sat(store_sat), .store_sel(store_sel), .ovf_clr(ovf_clr),
        .acc_a(acc_a), .acc_b(acc_b), .ovf(ovf), .store_word(store_word)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic        sel;
        logic [15:0] x;
        logic [15:0] y;
        logic        uns;
        logic        frac;
        logic [39:0] ea;
        logic [39:0] eb;
    } vec_t;

    localparam vec_t VEC [18] = '{
        '{4'd2,  1'b0, 16'h0003, 16'h0005, 1'b0, 1'b0, 40'h00_0000_000F, 40'h0},
        '{4'd4,  1'b0, 16'hFFFE, 16'h0004, 1'b0, 1'b0, 40'h00_0000_0007, 40'h0},
        '{4'd5,  1'b0, 16'h000A, 16'h000A, 1'b0, 1'b0, 40'hFF_FFFF_FFA3, 40'h0},
        '{4'd3,  1'b1, 16'h0006, 16'h0007, 1'b0, 1'b0, 40'hFF_FFFF_FFA3, 40'hFF_FFFF_FFD6},
        '{4'd8,  1'b0, 16'h1234, 16'h5678, 1'b0, 1'b0, 40'hFF_FFFF_FF79, 40'hFF_FFFF_FFD6},
        '{4'd9,  1'b1, 16'hABCD, 16'h0101, 1'b0, 1'b0, 40'hFF_FFFF_FF79, 40'h00_0000_005D},
        '{4'd10, 1'b0, 16'h7777, 16'h3333, 1'b0, 1'b0, 40'h00_0000_0087, 40'h00_0000_005D},
        '{4'd0,  1'b0, 16'h0009, 16'h0009, 1'b0, 1'b0, 40'h00_0000_0087, 40'h00_0000_005D},
        '{4'd6,  1'b1, 16'h000A, 16'h0003, 1'b0, 1'b0, 40'h00_0000_0087, 40'h00_0000_0031},
        '{4'd7,  1'b1, 16'hFFFB, 16'h0004, 1'b0, 1'b0, 40'h00_0000_0087, 40'h00_0000_0082},
        '{4'd2,  1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 40'h00_FFFE_0001, 40'h00_0000_0082},
        '{4'd2,  1'b0, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 40'h00_0000_0001, 40'h00_0000_0082},
        '{4'd2,  1'b1, 16'h4000, 16'h4000, 1'b0, 1'b1, 40'h00_0000_0001, 40'h00_2000_0000},
        '{4'd2,  1'b1, 16'h8000, 16'h8000, 1'b0, 1'b1, 40'h00_0000_0001, 40'h00_7FFF_FFFF},
        '{4'd2,  1'b0, 16'h8000, 16'h8000, 1'b1, 1'b1, 40'h00_8000_0000, 40'h00_7FFF_FFFF},
        '{4'd1,  1'b0, 16'h1111, 16'h2222, 1'b0, 1'b0, 40'h0,            40'h00_7FFF_FFFF},
        '{4'd6,  1'b0, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 40'h00_FFFE_0001, 40'h00_7FFF_FFFF},
        '{4'd1,  1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 40'h00_FFFE_0001, 40'h0}
    };

    task automatic chk(input string req, input logic [39:0] got, input logic [39:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic step(input logic [3:0] o, input logic s, input logic [15:0] xv,
                        input logic [15:0] yv, input logic u, input logic f,
                        input logic sa, input logic sb, input logic ss);
        op = o; acc_sel = s; x = xv; y = yv; unsigned_mode = u; frac_mode = f;
        sat_en_a = sa; sat_en_b = sb; super_sat = ss;
        @(negedge clk);
        op = 4'd0; ovf_clr = 1'b0;
    endtask

    task automatic store_chk(input string req, input logic sel, input logic cv,
                             input logic ss, input logic [15:0] exp);
        store_sel = sel; convergent = cv; store_sat = ss;
        #1;
        chk(req, {24'h0, store_word}, {24'h0, exp});
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 acc_a", acc_a, 40'h0);
        chk("R1 acc_b", acc_b, 40'h0);
        chk("R1 ovf", {36'h0, ovf}, 40'h0);
        chk("R1 store", {24'h0, store_word}, 40'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6 R7 R8: chained table
        for (int i = 0; i < 18; i++) begin
            step(VEC[i].op, VEC[i].sel, VEC[i].x, VEC[i].y, VEC[i].uns, VEC[i].frac,
                 1'b0, 1'b0, 1'b0);
            chk($sformatf("R2-R8 vec %0d acc_a", i), acc_a, VEC[i].ea);
            chk($sformatf("R2-R8 vec %0d acc_b", i), acc_b, VEC[i].eb);
        end

        // R11: flag from unsigned product stays set, then clears
        chk("R11 sticky", {36'h0, ovf}, 40'h1);
        ovf_clr = 1'b1;
        step(4'd0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R11 clear", {36'h0, ovf}, 40'h0);
        chk("R11 clear keeps acc", acc_a, 40'h00_FFFE_0001);

        // R9: normal saturation positive, other enable ignored, negative
        step(4'd2, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9 pos clamp", acc_a, 40'h00_7FFF_FFFF);
        chk("R11 lo flag A", {36'h0, ovf}, 40'h1);
        step(4'd2, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9 other enable ignored", acc_b, 40'h00_FFFE_0001);
        chk("R11 lo flag B", {36'h0, ovf}, 40'h5);
        step(4'd3, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R9 neg clamp", acc_b, 40'hFF_8000_0000);

        // R10: super saturation positive, then wrap with enable clear
        ovf_clr = 1'b1;
        step(4'd1, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R1 clear via op", acc_a, 40'h0);
        for (int k = 0; k < 200; k++)
            step(4'd4, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R10 super pos", acc_a, 40'h7F_FFFF_FFFF);
        chk("R11 both A flags", {36'h0, ovf}, 40'h3);
        step(4'd4, 1'b0, 16'h0001, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10 wrap", acc_a, 40'h80_0000_0000);

        // R10: super saturation negative on B
        step(4'd1, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 200; k++)
            step(4'd5, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R10 super neg", acc_b, 40'h80_0000_0000);
        chk("R11 all flags", {36'h0, ovf}, 40'hF);

        // R12 R13: rounding
        step(4'd2, 1'b0, 16'h0005, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        store_chk("R12 tie up", 1'b0, 1'b0, 1'b0, 16'h0003);
        store_chk("R13 tie to even", 1'b0, 1'b1, 1'b0, 16'h0002);
        step(4'd2, 1'b0, 16'h0003, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        store_chk("R12 odd tie", 1'b0, 1'b0, 1'b0, 16'h0002);
        store_chk("R13 odd tie", 1'b0, 1'b1, 1'b0, 16'h0002);
        step(4'd2, 1'b0, 16'h0005, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step(4'd4, 1'b0, 16'h0001, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        store_chk("R12 above half", 1'b0, 1'b0, 1'b0, 16'h0003);
        store_chk("R13 above half", 1'b0, 1'b1, 1'b0, 16'h0003);
        step(4'd5, 1'b0, 16'h0001, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step(4'd5, 1'b0, 16'h0001, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        store_chk("R12 below half", 1'b0, 1'b0, 1'b0, 16'h0002);
        store_chk("R13 below half", 1'b0, 1'b1, 1'b0, 16'h0002);

        // R14: store clamp
        step(4'd2, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        store_chk("R14 pos clamp", 1'b0, 1'b0, 1'b1, 16'h7FFF);
        store_chk("R14 pos raw", 1'b0, 1'b0, 1'b0, 16'hFFFE);
        step(4'd3, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        store_chk("R14 neg clamp", 1'b1, 1'b0, 1'b1, 16'h8000);
        store_chk("R14 neg raw", 1'b1, 1'b1, 1'b0, 16'h0002);

        // R1: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 rerst acc_a", acc_a, 40'h0);
        chk("R1 rerst acc_b", acc_b, 40'h0);
        chk("R1 rerst ovf", {36'h0, ovf}, 40'h0);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule